// File: doc/BRIEF.md
# Sampling Tap Drift Corrector

This block keeps the sampling point of a tuned high-speed card interface on a good delay-line tap after tuning has finished. Each time the surrounding controller raises a check strobe, the block looks at the drift status that the delay line reports. It then does one of three things: it steps the current sampling tap up or down by one position, it flags that a full retune is needed, or it does nothing. The block tracks the current tap itself. The controller seeds that tap with the tuning result through a load input.

Two correction styles are supported. In automatic mode the delay line moves the tap itself, so the block only watches for a correction error. In manual mode the block moves the tap. Outside double-data-rate timing, manual mode acts on the delay line's up/down/error request bits. In double-data-rate timing it acts on the command-line sample-compare bits instead. A per-tap bad mask can veto a move. When a move is vetoed, the tuning compare bitmap for the current tap decides whether a retune is requested. In the four-tap variant, the value sent to the tap-set register is half the tap index.

Top module: `tap_drift_corr`

## Requirements
- R1: After reset the current tap is 0 and the tap-write, status-clear and retune outputs are all low. The written tap value is 0.
- R2: A load sets the current tap to `load_tap_i` one cycle later. It produces no tap write, no status clear and no retune, and it overrides a check in the same cycle. Without a load or a check strobe, the current tap holds its value.
- R3: A check strobe has no effect in any of these cases: `timing_ok_i` is low, `tuning_i` is high, or both `ddr_mode_i` and `half_tap_i` are high.
- R4: In automatic mode, only drift bit 2 (error) is examined. If it is set, the block pulses both status clear and retune. Otherwise nothing happens, whatever bits 0 and 1 hold.
- R5: In manual mode outside double-data-rate, drift bit 2 (error) gives retune. If bit 2 is clear, bit 1 (up) increments the tap. If bits 1 and 2 are clear, bit 0 (down) decrements it.
- R6: In manual mode, a check with all three drift bits clear does nothing at all. A check with any drift bit set pulses status clear.
- R7: In manual double-data-rate mode, the drift up/down/error bits only gate the check. The direction comes from `cmd_cmp_i`: bit 24 set alone steps up, bit 8 set alone steps down, both set gives retune, and neither set gives no tap change.
- R8: Tap arithmetic is modulo NUM_TAPS: stepping up from NUM_TAPS-1 gives 0, and stepping down from 0 gives NUM_TAPS-1.
- R9: If the stepped-to tap has its bit set in `bad_tap_mask_i`, the tap is not changed and no write occurs. In that case retune equals bit [current tap] of `tune_map_i`.
- R10: Every accepted step pulses `tap_wr_o`. `tap_wr_val_o` then carries the new tap index, or the index shifted right by one when `half_tap_i` is set. The value holds between writes.
- R11: All three outputs are registered single-cycle pulses that appear in the cycle after the strobe. Tap write and retune never occur together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Seed the current tap from `load_tap_i` |
| load_tap_i | input | TAP_W | Tap value to load (below NUM_TAPS) |
| check_i | input | 1 | Check strobe, one per drift event |
| timing_ok_i | input | 1 | Interface is in a tuned high-speed timing mode |
| tuning_i | input | 1 | Tuning in progress |
| auto_mode_i | input | 1 | 1 = automatic correction, 0 = manual |
| ddr_mode_i | input | 1 | Double-data-rate timing active |
| half_tap_i | input | 1 | Four-tap variant: written value is tap/2 |
| drift_req_i | input | 3 | Drift status: bit0 down, bit1 up, bit2 error |
| cmd_cmp_i | input | 32 | Command compare status: bit8 down, bit24 up |
| bad_tap_mask_i | input | NUM_TAPS | Taps that must not be selected |
| tune_map_i | input | NUM_TAPS | Per-tap compare result stored from tuning |
| tap_o | output | TAP_W | Current tap index |
| tap_wr_o | output | 1 | Tap-set register write pulse |
| tap_wr_val_o | output | TAP_W | Value for the tap-set register |
| status_clr_o | output | 1 | Pulse to clear the drift status |
| retune_o | output | 1 | Pulse requesting a full retune |

## Verification
The assertions assume that `load_tap_i` is always below NUM_TAPS whenever `load_i` is high. They also assume that the check strobe is a synchronous single-cycle signal with no other timing relation to the mode inputs. The stimulus keeps every loaded tap value inside the legal range by reducing it modulo NUM_TAPS. The mode, mask and status inputs are allowed to change freely in every cycle, so mode switches between consecutive strobes are also covered. Directed sequences reach the wrap points, the bad-tap veto with both tuning-map polarities, and every gating condition. A free-running phase then mixes strobes, loads and modes against the behavioural model.

// File: rtl/tap_drift_pkg.sv
package tap_drift_pkg;
    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_UP     = 2'd1,
        ACT_DOWN   = 2'd2,
        ACT_RETUNE = 2'd3
    } drift_act_e;

    localparam int DRIFT_DOWN_BIT = 0;
    localparam int DRIFT_UP_BIT   = 1;
    localparam int DRIFT_ERR_BIT  = 2;
    localparam int CMD_DOWN_BIT   = 8;
    localparam int CMD_UP_BIT     = 24;
endpackage

// File: rtl/drift_req_decode.sv
module drift_req_decode
    import tap_drift_pkg::*;
(
    input  logic        auto_mode,
    input  logic        ddr_mode,
    input  logic [2:0]  drift_req,
    input  logic [31:0] cmd_cmp,
    output drift_act_e  act,
    output logic        clear_req
);
    logic cmd_up, cmd_dn;

    assign cmd_up = cmd_cmp[CMD_UP_BIT];
    assign cmd_dn = cmd_cmp[CMD_DOWN_BIT];

    always_comb begin
        act       = ACT_NONE;
        clear_req = 1'b0;
        if (auto_mode) begin
            // hardware moves the tap itself; only an error matters
            if (drift_req[DRIFT_ERR_BIT]) begin
                act       = ACT_RETUNE;
                clear_req = 1'b1;
            end
        end else if (|drift_req) begin
            clear_req = 1'b1;
            if (ddr_mode) begin
                if (cmd_up && cmd_dn)  act = ACT_RETUNE;
                else if (cmd_up)       act = ACT_UP;
                else if (cmd_dn)       act = ACT_DOWN;
            end else begin
                if (drift_req[DRIFT_ERR_BIT])       act = ACT_RETUNE;
                else if (drift_req[DRIFT_UP_BIT])   act = ACT_UP;
                else if (drift_req[DRIFT_DOWN_BIT]) act = ACT_DOWN;
            end
        end
    end
endmodule

// File: rtl/tap_stepper.sv
module tap_stepper #(
    parameter int NUM_TAPS = 8,
    parameter int TAP_W    = $clog2(NUM_TAPS)
) (
    input  logic [TAP_W-1:0]    cur_tap,
    input  logic                step_up,
    input  logic [NUM_TAPS-1:0] bad_mask,
    output logic [TAP_W-1:0]    next_tap,
    output logic                next_bad
);
    localparam logic [TAP_W-1:0] TOP_TAP = TAP_W'(NUM_TAPS - 1);

    always_comb begin
        if (step_up) next_tap = (cur_tap == TOP_TAP) ? '0 : cur_tap + 1'b1;
        else         next_tap = (cur_tap == '0) ? TOP_TAP : cur_tap - 1'b1;
        next_bad = bad_mask[next_tap];
    end
endmodule

// File: rtl/tap_drift_corr.sv
module tap_drift_corr
    import tap_drift_pkg::*;
#(
    parameter int NUM_TAPS = 8,
    parameter int TAP_W    = $clog2(NUM_TAPS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [TAP_W-1:0]    load_tap_i,
    input  logic                check_i,
    input  logic                timing_ok_i,
    input  logic                tuning_i,
    input  logic                auto_mode_i,
    input  logic                ddr_mode_i,
    input  logic                half_tap_i,
    input  logic [2:0]          drift_req_i,
    input  logic [31:0]         cmd_cmp_i,
    input  logic [NUM_TAPS-1:0] bad_tap_mask_i,
    input  logic [NUM_TAPS-1:0] tune_map_i,
    output logic [TAP_W-1:0]    tap_o,
    output logic                tap_wr_o,
    output logic [TAP_W-1:0]    tap_wr_val_o,
    output logic                status_clr_o,
    output logic                retune_o
);
    typedef struct packed {
        logic [TAP_W-1:0] tap;
        logic             wr;
        logic [TAP_W-1:0] wr_val;
        logic             clr;
        logic             retune;
    } corr_state_t;

    corr_state_t state_d, state_q;

    drift_act_e       act;
    logic             clear_req;
    logic             active;
    logic [TAP_W-1:0] step_tap;
    logic             step_bad;

    drift_req_decode u_decode (
        .auto_mode (auto_mode_i),
        .ddr_mode  (ddr_mode_i),
        .drift_req (drift_req_i),
        .cmd_cmp   (cmd_cmp_i),
        .act       (act),
        .clear_req (clear_req)
    );

    tap_stepper #(.NUM_TAPS(NUM_TAPS), .TAP_W(TAP_W)) u_step (
        .cur_tap  (state_q.tap),
        .step_up  (act == ACT_UP),
        .bad_mask (bad_tap_mask_i),
        .next_tap (step_tap),
        .next_bad (step_bad)
    );

    // four-tap double-data-rate: retuning cannot help, skip entirely
    assign active = check_i && timing_ok_i && !tuning_i && !(ddr_mode_i && half_tap_i);

    always_comb begin
        state_d        = state_q;
        state_d.wr     = 1'b0;
        state_d.clr    = 1'b0;
        state_d.retune = 1'b0;
        if (load_i) begin
            state_d.tap = load_tap_i;
        end else if (active) begin
            state_d.clr = clear_req;
            unique case (act)
                ACT_RETUNE: state_d.retune = 1'b1;
                ACT_UP, ACT_DOWN: begin
                    if (step_bad) begin
                        state_d.retune = tune_map_i[state_q.tap];
                    end else begin
                        state_d.tap    = step_tap;
                        state_d.wr     = 1'b1;
                        state_d.wr_val = half_tap_i ? (step_tap >> 1) : step_tap;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign tap_o        = state_q.tap;
    assign tap_wr_o     = state_q.wr;
    assign tap_wr_val_o = state_q.wr_val;
    assign status_clr_o = state_q.clr;
    assign retune_o     = state_q.retune;
endmodule

// File: rtl/tap_drift_corr_chk.sv
module tap_drift_corr_chk #(
    parameter int NUM_TAPS = 8,
    parameter int TAP_W    = $clog2(NUM_TAPS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_i,
    input logic [TAP_W-1:0] load_tap_i,
    input logic             check_i,
    input logic             timing_ok_i,
    input logic             tuning_i,
    input logic             auto_mode_i,
    input logic             half_tap_i,
    input logic [2:0]       drift_req_i,
    input logic [TAP_W-1:0] tap_o,
    input logic             tap_wr_o,
    input logic [TAP_W-1:0] tap_wr_val_o,
    input logic             status_clr_o,
    input logic             retune_o
);
    assert_wr_after_check_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tap_wr_o |-> $past(check_i));
    assert_retune_after_check_R11: assert property (@(posedge clk) disable iff (!rst_n)
        retune_o |-> $past(check_i));
    assert_clr_after_check_R11: assert property (@(posedge clk) disable iff (!rst_n)
        status_clr_o |-> $past(check_i));
    assert_wr_retune_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(tap_wr_o && retune_o));
    assert_tuning_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (check_i && tuning_i) |=> !(tap_wr_o || retune_o || status_clr_o));
    assert_load_sets_tap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (tap_o == $past(load_tap_i)) && !tap_wr_o && !retune_o);
    assert_tap_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !check_i) |=> $stable(tap_o));
    assert_auto_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (check_i && !load_i && auto_mode_i && !drift_req_i[2]) |=>
        !(tap_wr_o || retune_o || status_clr_o));
    assert_write_value_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_wr_o && !$past(half_tap_i)) |-> (tap_wr_val_o == tap_o));
    assert_write_half_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_wr_o && $past(half_tap_i)) |-> (tap_wr_val_o == (tap_o >> 1)));
endmodule

bind tap_drift_corr tap_drift_corr_chk #(.NUM_TAPS(NUM_TAPS), .TAP_W(TAP_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (load_i),
    .load_tap_i   (load_tap_i),
    .check_i      (check_i),
    .timing_ok_i  (timing_ok_i),
    .tuning_i     (tuning_i),
    .auto_mode_i  (auto_mode_i),
    .half_tap_i   (half_tap_i),
    .drift_req_i  (drift_req_i),
    .tap_o        (tap_o),
    .tap_wr_o     (tap_wr_o),
    .tap_wr_val_o (tap_wr_val_o),
    .status_clr_o (status_clr_o),
    .retune_o     (retune_o)
);

// File: tb/tap_drift_corr_tb_top.sv
module tap_drift_corr_tb_top;
    localparam int N  = 8;
    localparam int TW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_i = 1'b0;
    logic [TW-1:0] load_tap_i = '0;
    logic          check_i = 1'b0;
    logic          timing_ok_i = 1'b1;
    logic          tuning_i = 1'b0;
    logic          auto_mode_i = 1'b0;
    logic          ddr_mode_i = 1'b0;
    logic          half_tap_i = 1'b0;
    logic [2:0]    drift_req_i = '0;
    logic [31:0]   cmd_cmp_i = '0;
    logic [N-1:0]  bad_tap_mask_i = '0;
    logic [N-1:0]  tune_map_i = '0;
    logic [TW-1:0] tap_o;
    logic          tap_wr_o;
    logic [TW-1:0] tap_wr_val_o;
    logic          status_clr_o;
    logic          retune_o;

    int n_checks = 0;
    int n_fails  = 0;
    int m_tap = 0, m_val = 0;
    bit m_wr = 0, m_clr = 0, m_rt = 0;

    always #5 clk = ~clk;

    tap_drift_corr #(.NUM_TAPS(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_tap_i(load_tap_i),
        .check_i(check_i), .timing_ok_i(timing_ok_i), .tuning_i(tuning_i),
        .auto_mode_i(auto_mode_i), .ddr_mode_i(ddr_mode_i), .half_tap_i(half_tap_i),
        .drift_req_i(drift_req_i), .cmd_cmp_i(cmd_cmp_i),
        .bad_tap_mask_i(bad_tap_mask_i), .tune_map_i(tune_map_i),
        .tap_o(tap_o), .tap_wr_o(tap_wr_o), .tap_wr_val_o(tap_wr_val_o),
        .status_clr_o(status_clr_o), .retune_o(retune_o)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // behavioural reference: next outputs from present inputs
    task automatic model();
        m_wr = 0; m_clr = 0; m_rt = 0;
        if (load_i) begin
            m_tap = int'(load_tap_i);
        end else if (check_i && timing_ok_i && !tuning_i && !(ddr_mode_i && half_tap_i)) begin
            int dir = 0;
            if (auto_mode_i) begin
                if (drift_req_i[2]) begin m_clr = 1; m_rt = 1; end
            end else if (drift_req_i != 0) begin
                m_clr = 1;
                if (ddr_mode_i) begin
                    if (cmd_cmp_i[24] && cmd_cmp_i[8]) m_rt = 1;
                    else if (cmd_cmp_i[24]) dir = 1;
                    else if (cmd_cmp_i[8])  dir = -1;
                end else if (drift_req_i[2]) m_rt = 1;
                else if (drift_req_i[1]) dir = 1;
                else if (drift_req_i[0]) dir = -1;
            end
            if (dir != 0) begin
                int nt = (m_tap + dir + N) % N;
                if (bad_tap_mask_i[nt]) m_rt = tune_map_i[m_tap];
                else begin
                    m_tap = nt;
                    m_wr  = 1;
                    m_val = half_tap_i ? nt / 2 : nt;
                end
            end
        end
    endtask

    task automatic step(input string tag);
        model();
        @(posedge clk);
        #1;
        chk(tag, "tap_o", int'(tap_o), m_tap);
        chk(tag, "tap_wr_o", int'(tap_wr_o), int'(m_wr));
        chk(tag, "tap_wr_val_o", int'(tap_wr_val_o), m_val);
        chk(tag, "status_clr_o", int'(status_clr_o), int'(m_clr));
        chk(tag, "retune_o", int'(retune_o), int'(m_rt));
        load_i = 0; check_i = 0;
    endtask

    task automatic do_load(input int t, input string tag);
        load_i = 1; load_tap_i = TW'(t);
        step(tag);
    endtask

    task automatic do_check(input logic [2:0] drift, input logic [31:0] cmd, input string tag);
        check_i = 1; drift_req_i = drift; cmd_cmp_i = cmd;
        step(tag);
        step(tag);   // the following cycle must be quiet (single pulse)
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        step("R1");
        // R2 load
        do_load(5, "R2");
        step("R2");
        // R5 manual priorities
        do_check(3'b010, 32'h0, "R5");        // up -> 6
        do_check(3'b111, 32'h0, "R5");        // error wins
        do_check(3'b011, 32'h0, "R5");        // up beats down -> 7
        do_check(3'b001, 32'h0, "R5");        // down -> 6
        // R6 no status bits
        do_check(3'b000, 32'h0100_0100, "R6");
        // R8 wraps
        do_load(7, "R8");
        do_check(3'b010, 32'h0, "R8");        // -> 0
        do_check(3'b001, 32'h0, "R8");        // -> 7
        // R4 auto mode
        auto_mode_i = 1;
        do_check(3'b011, 32'h0, "R4");
        do_check(3'b100, 32'h0, "R4");
        auto_mode_i = 0;
        // R7 double data rate
        ddr_mode_i = 1;
        do_load(2, "R7");
        do_check(3'b001, 32'h0100_0000, "R7"); // up -> 3
        do_check(3'b010, 32'h0000_0100, "R7"); // down -> 2
        do_check(3'b001, 32'h0100_0100, "R7"); // both -> retune
        do_check(3'b010, 32'h0, "R7");         // clear only
        do_check(3'b100, 32'h0100_0000, "R7"); // error bit ignored for direction -> 3
        ddr_mode_i = 0;
        // R9 bad tap veto
        do_load(3, "R9");
        bad_tap_mask_i = 8'b0001_0000; tune_map_i = 8'b0000_1000;
        do_check(3'b010, 32'h0, "R9");
        tune_map_i = 8'b0;
        do_check(3'b010, 32'h0, "R9");
        do_check(3'b001, 32'h0, "R9");         // 2 not bad -> moves
        bad_tap_mask_i = '0;
        // R10 half write value
        half_tap_i = 1;
        do_load(6, "R10");
        do_check(3'b010, 32'h0, "R10");        // tap 7, value 3
        do_check(3'b010, 32'h0, "R10");        // tap 0, value 0
        // R3 gating
        timing_ok_i = 0; do_check(3'b010, 32'h0, "R3"); timing_ok_i = 1;
        tuning_i = 1;    do_check(3'b100, 32'h0, "R3"); tuning_i = 0;
        ddr_mode_i = 1;  do_check(3'b001, 32'h0100_0000, "R3"); ddr_mode_i = 0;
        half_tap_i = 0;
        // R2 load overrides check
        check_i = 1; drift_req_i = 3'b010; load_i = 1; load_tap_i = 3'd4;
        step("R2");
        // R11 free-running mix
        for (int i = 0; i < 400; i++) begin
            load_i         = ($urandom % 8) == 0;
            load_tap_i     = TW'($urandom % N);
            check_i        = $urandom % 2;
            timing_ok_i    = ($urandom % 8) != 0;
            tuning_i       = ($urandom % 8) == 0;
            auto_mode_i    = $urandom % 2;
            ddr_mode_i     = $urandom % 2;
            half_tap_i     = $urandom % 2;
            drift_req_i    = 3'($urandom);
            cmd_cmp_i      = $urandom;
            bad_tap_mask_i = N'($urandom & $urandom);
            tune_map_i     = N'($urandom);
            step("R11");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule